// File: doc/BRIEF.md
# Command-Response Buffer Control Unit

This block is the device-side control area of a shared-memory command/response interface to a security coprocessor. A host reaches it through a simple memory-mapped register bus. The block holds one locality, which the host claims and gives back through a control register. It also holds a power state, idle or ready, which moves only through self-clearing request strobes. A data region serves as one unified buffer for both the command and the response. Read-only descriptors give the size and the 64-bit address of that buffer, each address split into a low word and a high word.

The host claims the locality, asks for the ready state and writes a command into the buffer. It then sets the start register and polls it until it reads zero. A stub execution engine stands in for real command processing. After a fixed number of cycles it writes a ten-byte response header into the first three buffer words and clears the start register. Setting the cancel register while a command runs stops the engine at once. The engine then writes a response that carries a nonzero result code. A start that arrives while the unit is idle, or without the locality, is dropped and raises a sticky error flag. Only a completed go-idle request clears that flag.

Reads return data one cycle after the request. Byte n of the buffer sits at bus offset 0x080 + n, in lane (n mod 4) of the 32-bit word, with the lowest byte address in bits 7:0.

Top module: `crb_ctrl_unit`

## Requirements
- R1: After reset, locality state (0x000) reads 0x81 (bit 7 valid = 1, bit 1 assigned = 0, bit 0 established = 1), status (0x044) reads 0x2 (bit 1 idle = 1, bit 0 error = 0), and request (0x040), cancel (0x048) and start (0x04C) read 0.
- R2: A write to locality control (0x008) with bit 0 set makes the assigned bit read 1, and one with bit 1 set makes it read 0. When both bits are set in one write, release wins.
- R3: Writing request bit 0 (go-ready) or bit 1 (go-idle) sets that bit. It reads back as 1 for exactly PWR_CYCLES cycles after the write edge, then clears itself. At that same edge the status idle bit takes the requested value.
- R4: If both request bits are set in one write, go-idle wins. Both bits clear together, and the unit ends up idle.
- R5: Writing start bit 0 while the unit is idle, or while the locality is not assigned, is ignored. The start register stays 0, the buffer is untouched, and the status error bit becomes 1.
- R6: The error bit stays set through any other activity, including a go-ready completion and an accepted command. It clears only when a go-idle request completes.
- R7: An accepted start makes the start register read 1 for EXEC_CYCLES cycles, then 0. At that edge buffer bytes 0..9 become 0x80, 0x01, then the length 10 as a big-endian 32-bit value in bytes 2..5, then result code 0 as a big-endian value in bytes 6..9.
- R8: A write of 1 to cancel while a command runs ends the command at that write's edge. The response then carries the result code CANCEL_CODE (default 0x00000A5C). Cancel reads back its stored bit 0, and writing 0 clears it.
- R9: A cancel write that lands on the same edge as normal completion yields CANCEL_CODE. A cancel write one edge later leaves result code 0.
- R10: The command size (0x058) and response size (0x064) both read BUF_WORDS*4 (128 by default). The command address (0x05C low, 0x060 high) and the response address (0x068 low, 0x06C high) both read BASE_ADDR + 0x80, which is 0x00000001_FED40080 by default.
- R11: Buffer words written over the bus read back unchanged. A response overwrites only words 0..2, so word 3 and the last word keep their contents.
- R12: Read data appears on bus_rdata one cycle after the read request. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |

## Verification
Two functions can meet on one clock edge: the engine's normal completion and a host cancel write. The bench places the cancel write exactly EXEC_CYCLES edges after the accepted start, so both act on the same edge. It then expects the cancel result code in buffer word 2. The bench repeats the run with the cancel one edge later and expects a zero code, and an earlier run cancels mid-command. Together these three runs pin the priority down on both sides of the boundary.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  // register offsets (fixed map seen by the host driver)
  localparam logic [ADDR_W-1:0] OFF_LOC_STATE = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_LOC_CTRL  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_REQ       = 12'h040;
  localparam logic [ADDR_W-1:0] OFF_STS       = 12'h044;
  localparam logic [ADDR_W-1:0] OFF_CANCEL    = 12'h048;
  localparam logic [ADDR_W-1:0] OFF_START     = 12'h04C;
  localparam logic [ADDR_W-1:0] OFF_CMD_SIZE  = 12'h058;
  localparam logic [ADDR_W-1:0] OFF_CMD_LO    = 12'h05C;
  localparam logic [ADDR_W-1:0] OFF_CMD_HI    = 12'h060;
  localparam logic [ADDR_W-1:0] OFF_RSP_SIZE  = 12'h064;
  localparam logic [ADDR_W-1:0] OFF_RSP_LO    = 12'h068;
  localparam logic [ADDR_W-1:0] OFF_RSP_HI    = 12'h06C;
  localparam logic [ADDR_W-1:0] OFF_BUF       = 12'h080;

  // number of buffer words the stub response touches
  localparam int RSP_WORDS = 3;

  // Response header, byte n in lane n%4 of word n/4:
  //   bytes 0,1 = tag 0x80 0x01; bytes 2..5 = length 10 (big-endian);
  //   bytes 6..9 = result code (big-endian); bytes 10,11 = 0.
  function automatic logic [DATA_W-1:0] rsp_word(input int unsigned idx,
                                                 input logic [31:0] rc);
    case (idx)
      0:       return {8'h00, 8'h00, 8'h01, 8'h80};
      1:       return {rc[23:16], rc[31:24], 8'h0A, 8'h00};
      default: return {8'h00, 8'h00, rc[7:0], rc[15:8]};
    endcase
  endfunction
endpackage

// File: rtl/crb_locality.sv
module crb_locality (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_we,
  input  logic claim,
  input  logic give_back,
  output logic assigned
);
  logic own_q, own_n, own_en;

  always_comb begin
    own_en = ctrl_we & (claim | give_back);
    own_n  = give_back ? 1'b0 : 1'b1;   // release wins over request
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      own_q <= 1'b0;
    else if (own_en) own_q <= own_n;
  end

  assign assigned = own_q;
endmodule

// File: rtl/crb_power.sv
module crb_power #(
  parameter int PWR_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_we,
  input  logic want_ready,
  input  logic want_idle,
  input  logic start_reject,
  output logic idle,
  output logic err,
  output logic pend_ready,
  output logic pend_idle,
  output logic idle_done
);
  localparam int CW = $clog2(PWR_CYCLES + 1);

  logic          idle_q, idle_n, err_q, err_n;
  logic          pr_q, pr_n, pi_q, pi_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          done, en;

  always_comb begin
    idle_n    = idle_q;
    err_n     = err_q;
    pr_n      = pr_q;
    pi_n      = pi_q;
    cnt_n     = cnt_q;
    done      = (pr_q | pi_q) && (cnt_q == CW'(1));
    idle_done = done & pi_q;
    if (done) begin
      if (pi_q) begin           // go-idle has priority over go-ready
        idle_n = 1'b1;
        err_n  = 1'b0;
      end else begin
        idle_n = 1'b0;
      end
      pr_n = 1'b0;
      pi_n = 1'b0;
    end else if (pr_q | pi_q) begin
      cnt_n = cnt_q - CW'(1);
    end
    if (req_we && (want_ready || want_idle)) begin
      pr_n  = pr_n | want_ready;
      pi_n  = pi_n | want_idle;
      cnt_n = CW'(PWR_CYCLES);
    end
    if (start_reject) err_n = 1'b1;
    en = req_we | pr_q | pi_q | start_reject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b1;
      err_q  <= 1'b0;
      pr_q   <= 1'b0;
      pi_q   <= 1'b0;
      cnt_q  <= '0;
    end else if (en) begin
      idle_q <= idle_n;
      err_q  <= err_n;
      pr_q   <= pr_n;
      pi_q   <= pi_n;
      cnt_q  <= cnt_n;
    end
  end

  assign idle       = idle_q;
  assign err        = err_q;
  assign pend_ready = pr_q;
  assign pend_idle  = pi_q;
endmodule

// File: rtl/crb_engine.sv
module crb_engine #(
  parameter int          EXEC_CYCLES = 8,
  parameter logic [31:0] CANCEL_CODE = 32'h0000_0A5C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_we,
  input  logic        start_bit,
  input  logic        can_run,
  input  logic        cancel_we,
  input  logic        cancel_bit,
  output logic        busy,
  output logic        cancel_set,
  output logic        start_reject,
  output logic        rsp_we,
  output logic [31:0] rsp_rc
);
  localparam int CW = $clog2(EXEC_CYCLES + 1);

  logic          busy_q, busy_n, can_q, can_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          start_req, accept, finish, cancel_eff, en;

  always_comb begin
    cancel_eff   = cancel_we ? cancel_bit : can_q;
    start_req    = start_we & start_bit;
    accept       = start_req & ~busy_q & can_run;
    start_reject = start_req & ~busy_q & ~can_run;
    finish       = busy_q & ((cnt_q == CW'(1)) | cancel_eff);
    busy_n       = accept | (busy_q & ~finish);
    can_n        = cancel_eff;
    if (accept)      cnt_n = CW'(EXEC_CYCLES);
    else if (busy_q) cnt_n = cnt_q - CW'(1);
    else             cnt_n = cnt_q;
    en     = start_we | cancel_we | busy_q;
    rsp_we = finish;
    rsp_rc = cancel_eff ? CANCEL_CODE : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      can_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (en) begin
      busy_q <= busy_n;
      can_q  <= can_n;
      cnt_q  <= cnt_n;
    end
  end

  assign busy       = busy_q;
  assign cancel_set = can_q;
endmodule

// File: rtl/crb_buffer.sv
module crb_buffer import crb_pkg::*; #(
  parameter int WORDS = 32,
  localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [IW-1:0]     bus_idx,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              rsp_we,
  input  logic [31:0]       rsp_rc,
  input  logic [IW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DATA_W-1:0] word_q, word_n;
    logic              word_en;
    if (g < RSP_WORDS) begin : g_rsp
      // engine response has priority over a bus write on the same edge
      always_comb begin
        word_en = rsp_we | (bus_we && (bus_idx == IW'(g)));
        word_n  = rsp_we ? rsp_word(g, rsp_rc) : bus_wdata;
      end
    end else begin : g_plain
      always_comb begin
        word_en = bus_we && (bus_idx == IW'(g));
        word_n  = bus_wdata;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= word_n;
    end
    assign words[g] = word_q;
  end

  assign rd_word = words[rd_idx];
endmodule

// File: rtl/crb_ctrl_unit.sv
module crb_ctrl_unit import crb_pkg::*; #(
  parameter int          BUF_WORDS   = 32,
  parameter int          EXEC_CYCLES = 8,
  parameter int          PWR_CYCLES  = 4,
  parameter logic [63:0] BASE_ADDR   = 64'h0000_0001_FED4_0000,
  parameter logic [31:0] CANCEL_CODE = 32'h0000_0A5C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int              BUF_BYTES = BUF_WORDS * 4;
  localparam int              IDX_W     = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;
  localparam logic [ADDR_W:0] BUF_END   = (ADDR_W+1)'(OFF_BUF) + (ADDR_W+1)'(BUF_BYTES);
  localparam logic [63:0]     BUF_PHYS  = BASE_ADDR + 64'(OFF_BUF);

  // reset: asynchronous assert, synchronous release
  logic rst_s1_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  logic             wr_req, rd_req, in_buf;
  logic [IDX_W-1:0] buf_idx;
  logic             loc_ctrl_we, req_we, start_we, cancel_we, buf_we;

  always_comb begin
    wr_req      = bus_sel & bus_wr;
    rd_req      = bus_sel & ~bus_wr;
    in_buf      = ({1'b0, bus_addr} >= {1'b0, OFF_BUF}) && ({1'b0, bus_addr} < BUF_END);
    buf_idx     = IDX_W'((bus_addr - OFF_BUF) >> 2);
    loc_ctrl_we = wr_req && (bus_addr == OFF_LOC_CTRL);
    req_we      = wr_req && (bus_addr == OFF_REQ);
    start_we    = wr_req && (bus_addr == OFF_START);
    cancel_we   = wr_req && (bus_addr == OFF_CANCEL);
    buf_we      = wr_req && in_buf;
  end

  logic loc_assigned;
  logic st_idle, st_err, pend_ready, pend_idle, idle_done;
  logic eng_busy, cancel_set, start_reject, rsp_we;
  logic [31:0]       rsp_rc;
  logic [DATA_W-1:0] buf_word;

  crb_locality u_loc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctrl_we   (loc_ctrl_we),
    .claim     (bus_wdata[0]),
    .give_back (bus_wdata[1]),
    .assigned  (loc_assigned)
  );

  crb_power #(.PWR_CYCLES(PWR_CYCLES)) u_pwr (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .req_we       (req_we),
    .want_ready   (bus_wdata[0]),
    .want_idle    (bus_wdata[1]),
    .start_reject (start_reject),
    .idle         (st_idle),
    .err          (st_err),
    .pend_ready   (pend_ready),
    .pend_idle    (pend_idle),
    .idle_done    (idle_done)
  );

  crb_engine #(.EXEC_CYCLES(EXEC_CYCLES), .CANCEL_CODE(CANCEL_CODE)) u_eng (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .start_we     (start_we),
    .start_bit    (bus_wdata[0]),
    .can_run      (loc_assigned & ~st_idle),
    .cancel_we    (cancel_we),
    .cancel_bit   (bus_wdata[0]),
    .busy         (eng_busy),
    .cancel_set   (cancel_set),
    .start_reject (start_reject),
    .rsp_we       (rsp_we),
    .rsp_rc       (rsp_rc)
  );

  crb_buffer #(.WORDS(BUF_WORDS)) u_buf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_we    (buf_we),
    .bus_idx   (buf_idx),
    .bus_wdata (bus_wdata),
    .rsp_we    (rsp_we),
    .rsp_rc    (rsp_rc),
    .rd_idx    (buf_idx),
    .rd_word   (buf_word)
  );

  logic [DATA_W-1:0] rd_next, rdata_q;

  always_comb begin
    rd_next = '0;
    if (in_buf) begin
      rd_next = buf_word;
    end else begin
      case (bus_addr)
        OFF_LOC_STATE: rd_next = {24'h0, 1'b1, 5'b0, loc_assigned, 1'b1};
        OFF_REQ:       rd_next = {30'h0, pend_idle, pend_ready};
        OFF_STS:       rd_next = {30'h0, st_idle, st_err};
        OFF_CANCEL:    rd_next = {31'h0, cancel_set};
        OFF_START:     rd_next = {31'h0, eng_busy};
        OFF_CMD_SIZE,
        OFF_RSP_SIZE:  rd_next = DATA_W'(BUF_BYTES);
        OFF_CMD_LO,
        OFF_RSP_LO:    rd_next = BUF_PHYS[31:0];
        OFF_CMD_HI,
        OFF_RSP_HI:    rd_next = BUF_PHYS[63:32];
        default:       rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (rd_req)  rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/crb_ctrl_unit_chk.sv
module crb_ctrl_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic start_we,
  input logic start_bit,
  input logic loc_ctrl_we,
  input logic rel_bit,
  input logic busy,
  input logic assigned,
  input logic idle,
  input logic err,
  input logic pend_ready,
  input logic pend_idle,
  input logic idle_done,
  input logic rsp_we
);
  // R7: the response write ends the command
  p_finish_clears_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_we |=> !busy);

  // R5: a start with no locality or in idle raises the error flag
  p_reject_flags_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_we && start_bit && !busy && (idle || !assigned)) |=> err);

  // R5: a command only begins when the locality is held and the unit is ready
  p_busy_needs_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(assigned) && !$past(idle)));

  // R6: the error flag holds until a go-idle completes
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !idle_done) |=> err);

  // R3: a finished go-idle leaves the unit idle
  p_idle_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_idle) |-> idle);

  // R3: a finished go-ready alone leaves the unit ready
  p_ready_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pend_ready) && !$past(pend_idle) && !pend_idle) |-> !idle);

  // R2: release wins
  p_release_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_ctrl_we && rel_bit) |=> !assigned);
endmodule

bind crb_ctrl_unit crb_ctrl_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .start_we    (start_we),
  .start_bit   (bus_wdata[0]),
  .loc_ctrl_we (loc_ctrl_we),
  .rel_bit     (bus_wdata[1]),
  .busy        (eng_busy),
  .assigned    (loc_assigned),
  .idle        (st_idle),
  .err         (st_err),
  .pend_ready  (pend_ready),
  .pend_idle   (pend_idle),
  .idle_done   (idle_done),
  .rsp_we      (rsp_we)
);

// File: tb/crb_ctrl_unit_tb.sv
module crb_ctrl_unit_tb;
  localparam int          LAT   = 8;
  localparam int          PLAT  = 4;
  localparam logic [31:0] CCODE = 32'h0000_0A5C;

  localparam logic [11:0] A_LOC = 12'h000, A_LCTL = 12'h008, A_REQ = 12'h040,
                          A_STS = 12'h044, A_CAN = 12'h048, A_START = 12'h04C,
                          A_CSZ = 12'h058, A_CLO = 12'h05C, A_CHI = 12'h060,
                          A_RSZ = 12'h064, A_RLO = 12'h068, A_RHI = 12'h06C,
                          A_W0 = 12'h080, A_W1 = 12'h084, A_W2 = 12'h088,
                          A_W3 = 12'h08C, A_WL = 12'h0FC;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #10 clk = ~clk;

  crb_ctrl_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  logic [31:0] exp_q[$];
  string       tag_q[$];
  int          vectors = 0;
  int          miscompares = 0;
  int          cyc = 0;
  logic        rd_prev = 1'b0;

  function automatic logic [31:0] pack4(input logic [7:0] b0, b1, b2, b3);
    return {b3, b2, b1, b0};
  endfunction

  // Scoreboard monitor: the read seen at one edge is compared at the next negedge.
  always @(posedge clk) rd_prev <= bus_sel && !bus_wr;

  always @(negedge clk) begin
    if (rd_prev && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if (bus_rdata !== e) begin
        miscompares++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", t, bus_rdata, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // every task is entered just after a negedge and uses one edge per access
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pwr(input logic [31:0] bits);
    wr(A_REQ, bits);
    idle(PLAT + 1);
  endtask

  initial begin
    logic [31:0] w0, w1, w2_ok, w2_can;
    w0     = pack4(8'h80, 8'h01, 8'h00, 8'h00);
    w1     = pack4(8'h00, 8'h0A, 8'h00, 8'h00);          // code 0 or CCODE: top bytes zero
    w2_ok  = pack4(8'h00, 8'h00, 8'h00, 8'h00);
    w2_can = pack4(CCODE[15:8], CCODE[7:0], 8'h00, 8'h00);

    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(A_LOC,   32'h81, "R1 loc state");
    rd(A_STS,   32'h2,  "R1 status");
    rd(A_START, 32'h0,  "R1 start");
    rd(A_REQ,   32'h0,  "R1 request");
    rd(A_CAN,   32'h0,  "R1 cancel");

    // R10 descriptors
    rd(A_CSZ, 32'd128,       "R10 cmd size");
    rd(A_RSZ, 32'd128,       "R10 rsp size");
    rd(A_CLO, 32'hFED4_0080, "R10 cmd lo");
    rd(A_CHI, 32'h1,         "R10 cmd hi");
    rd(A_RLO, 32'hFED4_0080, "R10 rsp lo");
    rd(A_RHI, 32'h1,         "R10 rsp hi");

    // R12 unmapped
    rd(12'h030, 32'h0, "R12 unmapped 0x030");
    rd(12'h07C, 32'h0, "R12 unmapped 0x07C");

    // R11 buffer storage
    wr(A_W0, 32'hDEAD_BEEF);
    wr(A_W3, 32'h1234_5678);
    wr(A_WL, 32'hCAFE_F00D);
    rd(A_W0, 32'hDEAD_BEEF, "R11 word0");
    rd(A_W3, 32'h1234_5678, "R11 word3");
    rd(A_WL, 32'hCAFE_F00D, "R11 last word");

    // R5 start while idle without locality
    wr(A_START, 32'h1);
    rd(A_START, 32'h0,         "R5 start ignored");
    rd(A_STS,   32'h3,         "R5 error set");
    rd(A_W0,    32'hDEAD_BEEF, "R5 buffer untouched");

    // R6 error holds; R2 request
    idle(5);
    wr(A_LCTL, 32'h1);
    rd(A_STS, 32'h3,  "R6 error sticky");
    rd(A_LOC, 32'h83, "R2 assigned");

    // R3 go-idle timing, R6 clear
    wr(A_REQ, 32'h2);
    rd(A_REQ, 32'h2, "R3 go-idle pending");
    idle(PLAT - 2);
    rd(A_REQ, 32'h2, "R3 go-idle still pending");
    rd(A_REQ, 32'h0, "R3 go-idle cleared");
    rd(A_STS, 32'h2, "R6 error cleared by go-idle");

    // R5 start while idle with locality
    wr(A_START, 32'h1);
    rd(A_START, 32'h0, "R5 idle start ignored");
    rd(A_STS,   32'h3, "R5 idle start error");
    pwr(32'h2);

    // R3 go-ready timing
    wr(A_REQ, 32'h1);
    rd(A_REQ, 32'h1, "R3 go-ready pending");
    idle(PLAT - 2);
    rd(A_REQ, 32'h1, "R3 go-ready still pending");
    rd(A_REQ, 32'h0, "R3 go-ready cleared");
    rd(A_STS, 32'h0, "R3 ready state");

    // R2 both bits -> released; R5 start without locality
    wr(A_LCTL, 32'h3);
    rd(A_LOC, 32'h81, "R2 release wins");
    wr(A_START, 32'h1);
    rd(A_START, 32'h0, "R5 no-locality start ignored");
    rd(A_STS,   32'h1, "R5 no-locality error");
    wr(A_LCTL, 32'h1);
    wr(A_LCTL, 32'h2);
    rd(A_LOC, 32'h81, "R2 release");
    wr(A_LCTL, 32'h1);
    rd(A_LOC, 32'h83, "R2 request again");

    // R7 accepted command, error still set (R6)
    wr(A_START, 32'h1);
    rd(A_START, 32'h1, "R7 start busy first");
    idle(LAT - 2);
    rd(A_START, 32'h1, "R7 start busy last");
    rd(A_START, 32'h0, "R7 start cleared");
    rd(A_W0, w0,           "R7 word0");
    rd(A_W1, w1,           "R7 word1");
    rd(A_W2, w2_ok,        "R7 word2 code 0");
    rd(A_W3, 32'h1234_5678, "R11 word3 kept");
    rd(A_WL, 32'hCAFE_F00D, "R11 last kept");
    rd(A_STS, 32'h1, "R6 error through command");
    pwr(32'h2);
    pwr(32'h1);
    rd(A_STS, 32'h0, "R6 cleared then ready");

    // R8 early cancel
    wr(A_START, 32'h1);
    idle(1);
    wr(A_CAN, 32'h1);
    rd(A_START, 32'h0,  "R8 cancel ends command");
    rd(A_W2,    w2_can, "R8 canceled code");
    rd(A_CAN,   32'h1,  "R8 cancel readback");
    wr(A_CAN, 32'h0);
    rd(A_CAN,   32'h0,  "R8 cancel cleared");

    // R9 cancel on the completion edge
    wr(A_W2, 32'hFFFF_FFFF);
    wr(A_START, 32'h1);
    idle(LAT - 1);
    wr(A_CAN, 32'h1);
    rd(A_START, 32'h0,  "R9 collision done");
    rd(A_W2,    w2_can, "R9 collision canceled code");
    wr(A_CAN, 32'h0);

    // R9 cancel one edge late
    wr(A_W2, 32'hFFFF_FFFF);
    wr(A_START, 32'h1);
    idle(LAT);
    wr(A_CAN, 32'h1);
    rd(A_W2,  w2_ok, "R9 late cancel code 0");
    rd(A_CAN, 32'h1, "R9 late cancel stored");
    wr(A_CAN, 32'h0);

    // R4 both power bits
    wr(A_REQ, 32'h3);
    rd(A_REQ, 32'h3, "R4 both pending");
    idle(PLAT);
    rd(A_REQ, 32'h0, "R4 both cleared");
    rd(A_STS, 32'h2, "R4 idle wins");

    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule